// File: doc/BRIEF.md
# Interrupt-Driven Accelerometer Burst Reader

This block turns a data-ready interrupt from a three-axis accelerometer into one stored sample record. A rising edge on the asynchronous data-ready line is synchronised and detected once. The block then asks for a shared SPI port. If the port is not granted, the sample is dropped and the block goes back to waiting.

With the grant held, it drives chip select low and runs a seven-byte burst through an external SPI byte engine. The first byte is the X-axis low-byte register address with the read flag set. The remaining six bytes are zeros whose only purpose is to clock data back.

The first returned byte is discarded. The other six form the X, Y and Z signed 16-bit values, low byte first. Each value is divided by four with truncation toward zero. The three results are written to a sample FIFO as three consecutive words, followed by a one-cycle completion pulse. When the FIFO reports fewer free bytes than one record needs, the whole record is discarded.

Top module: `accel_burst_reader`

## Requirements
- R1: While reset is high and after it falls with no stimulus, chip select is high (`cs_n_o`=1), and `bus_req_o`, `xfer_start_o`, `fifo_wr_o` and `rec_done_o` are all 0.
- R2: A rising edge of `drdy_i` raises `bus_req_o` after the third rising clock edge that follows the input change. While `drdy_i` stays high it starts no further request. Only a new low-to-high change triggers again.
- R3: If `bus_gnt_i` is 0 in the cycle after `bus_req_o` rises, `bus_req_o` falls after the next edge. Chip select then stays high, no byte transfer starts, no FIFO word is written and no completion pulse occurs.
- R4: With the grant, exactly seven byte transfers run, each started by a one-cycle `xfer_start_o` while chip select is low. The first transmitted byte is `X_LSB_ADDR` with bit 7 set (0x82 by default). The other six transmitted bytes are 0x00.
- R5: Chip select stays low until the seventh received byte has been captured. It rises, and `bus_req_o` falls, two cycles after the cycle in which the seventh `xfer_done_i` is seen.
- R6: Received byte 0 is ignored. Axis k (X=0, Y=1, Z=2) is the signed value {byte[2k+2], byte[2k+1]}, with the upper byte from the later transfer.
- R7: Each stored word equals the axis value divided by 4, truncated toward zero. For example, -5 gives -1, -1 gives 0, and -32768 gives -8192.
- R8: When the record is kept, `fifo_wr_o` is high for three consecutive cycles carrying X, Y, Z. The first write cycle is the one after chip select rises. `rec_done_o` pulses for the one cycle right after the last write.
- R9: The free-space check happens at the end of the burst. If `fifo_free_i` (in bytes) is below 6, no word is written and no completion pulse occurs. A value of exactly 6 keeps the record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drdy_i | input | 1 | Asynchronous data-ready interrupt from the sensor |
| bus_req_o | output | 1 | Request, then hold, of the shared SPI port |
| bus_gnt_i | input | 1 | Port grant, sampled in the cycle after a request rises |
| cs_n_o | output | 1 | Sensor chip select, active low |
| xfer_start_o | output | 1 | One-cycle start of one byte transfer |
| xfer_tx_o | output | 8 | Byte to transmit |
| xfer_done_i | input | 1 | Byte transfer finished, received byte valid |
| xfer_rx_i | input | 8 | Received byte |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 16 | Scaled axis word |
| fifo_free_i | input | FREE_W | FIFO free space in bytes |
| rec_done_o | output | 1 | One-cycle pulse after a record is written |

## Verification
Each result has a fixed lag from its stimulus. The request follows a `drdy_i` change set between edges by exactly three rising edges, and a refused grant clears it one edge later. Chip select rises two cycles after the last byte-done cycle, and the first FIFO write follows one cycle after that. The three writes are back to back, and the completion pulse comes one cycle after the last of them. The bench records the cycle number of each of these events at falling edges and compares it with the lag stated in R2, R3, R5 and R8. It checks the transmitted bytes and the stored words against values it derives from the received bytes using plain integer division.

// File: rtl/accel_pkg.sv
package accel_pkg;
  localparam int BYTE_W     = 8;
  localparam int SAMPLE_W   = 16;
  localparam int NUM_AXES   = 3;
  localparam int DATA_BYTES = NUM_AXES * (SAMPLE_W / BYTE_W);
  localparam int BURST_LEN  = DATA_BYTES + 1;
  localparam int IDX_W      = $clog2(BURST_LEN);
  localparam int AX_W       = $clog2(NUM_AXES);

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_SEND, ST_WAIT, ST_REL, ST_WR, ST_FIN
  } seq_state_t;
endpackage

// File: rtl/accel_edge_detect.sv
module accel_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[SYNC_STAGES-1:0], async_i};
  end

  // newest synchronised sample high, previous one low
  assign rise_o = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
endmodule

// File: rtl/accel_axis_scaler.sv
module accel_axis_scaler
  import accel_pkg::*;
(
  input  logic [DATA_BYTES-1:0][BYTE_W-1:0] bytes_i,
  output logic [NUM_AXES-1:0][SAMPLE_W-1:0] axis_o
);
  for (genvar k = 0; k < NUM_AXES; k++) begin : g_axis
    logic signed [SAMPLE_W-1:0] raw;
    logic signed [SAMPLE_W-1:0] bias;
    // bytes_i[0] holds received byte 1, so byte[2k+1] is bytes_i[2k]
    assign raw  = {bytes_i[2*k+1], bytes_i[2*k]};
    // adding 3 to negatives turns the floor shift into truncation toward zero
    assign bias = raw[SAMPLE_W-1] ? SAMPLE_W'(3) : '0;
    assign axis_o[k] = (raw + bias) >>> 2;
  end
endmodule

// File: rtl/accel_burst_fsm.sv
module accel_burst_fsm
  import accel_pkg::*;
#(
  parameter logic [7:0] X_LSB_ADDR = 8'h02,
  parameter int         FREE_W     = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              trig_i,
  output logic                              bus_req_o,
  input  logic                              bus_gnt_i,
  output logic                              cs_n_o,
  output logic                              xfer_start_o,
  output logic [BYTE_W-1:0]                 xfer_tx_o,
  input  logic                              xfer_done_i,
  input  logic [BYTE_W-1:0]                 xfer_rx_i,
  input  logic [FREE_W-1:0]                 fifo_free_i,
  output logic [DATA_BYTES-1:0][BYTE_W-1:0] rx_bytes_o,
  input  logic [NUM_AXES-1:0][SAMPLE_W-1:0] axis_i,
  output logic                              fifo_wr_o,
  output logic [SAMPLE_W-1:0]               fifo_data_o,
  output logic                              rec_done_o
);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(BURST_LEN - 1);
  localparam logic [AX_W-1:0]   LAST_AX  = AX_W'(NUM_AXES - 1);
  localparam logic [FREE_W-1:0] REC_SZ   = FREE_W'(DATA_BYTES);

  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  logic [AX_W-1:0]  widx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      idx          <= '0;
      widx         <= '0;
      bus_req_o    <= 1'b0;
      cs_n_o       <= 1'b1;
      xfer_start_o <= 1'b0;
      xfer_tx_o    <= '0;
      rx_bytes_o   <= '0;
      fifo_wr_o    <= 1'b0;
      fifo_data_o  <= '0;
      rec_done_o   <= 1'b0;
    end else begin
      xfer_start_o <= 1'b0;
      rec_done_o   <= 1'b0;
      unique case (state)
        ST_IDLE: if (trig_i) begin
          bus_req_o <= 1'b1;
          state     <= ST_REQ;
        end
        ST_REQ: if (bus_gnt_i) begin
          cs_n_o <= 1'b0;
          idx    <= '0;
          state  <= ST_SEND;
        end else begin
          bus_req_o <= 1'b0;
          state     <= ST_IDLE;
        end
        ST_SEND: begin
          xfer_start_o <= 1'b1;
          xfer_tx_o    <= (idx == '0) ? {1'b1, X_LSB_ADDR[6:0]} : '0;
          state        <= ST_WAIT;
        end
        ST_WAIT: if (xfer_done_i) begin
          if (idx != '0) rx_bytes_o[idx - 1'b1] <= xfer_rx_i;
          if (idx == LAST_IDX) state <= ST_REL;
          else begin
            idx   <= idx + 1'b1;
            state <= ST_SEND;
          end
        end
        ST_REL: begin
          cs_n_o    <= 1'b1;
          bus_req_o <= 1'b0;
          widx      <= '0;
          state     <= (fifo_free_i >= REC_SZ) ? ST_WR : ST_IDLE;
        end
        ST_WR: begin
          fifo_wr_o   <= 1'b1;
          fifo_data_o <= axis_i[widx];
          widx        <= widx + 1'b1;
          if (widx == LAST_AX) state <= ST_FIN;
        end
        ST_FIN: begin
          fifo_wr_o  <= 1'b0;
          rec_done_o <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/accel_burst_reader.sv
module accel_burst_reader
  import accel_pkg::*;
#(
  parameter logic [7:0] X_LSB_ADDR  = 8'h02,
  parameter int         FREE_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drdy_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              cs_n_o,
  output logic              xfer_start_o,
  output logic [7:0]        xfer_tx_o,
  input  logic              xfer_done_i,
  input  logic [7:0]        xfer_rx_i,
  output logic              fifo_wr_o,
  output logic [15:0]       fifo_data_o,
  input  logic [FREE_W-1:0] fifo_free_i,
  output logic              rec_done_o
);
  logic                              trig;
  logic [DATA_BYTES-1:0][BYTE_W-1:0] rx_bytes;
  logic [NUM_AXES-1:0][SAMPLE_W-1:0] axis;

  accel_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .async_i(drdy_i), .rise_o(trig)
  );

  accel_axis_scaler u_scale (.bytes_i(rx_bytes), .axis_o(axis));

  accel_burst_fsm #(.X_LSB_ADDR(X_LSB_ADDR), .FREE_W(FREE_W)) u_fsm (
    .clk(clk), .rst(rst), .trig_i(trig),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .cs_n_o(cs_n_o),
    .xfer_start_o(xfer_start_o), .xfer_tx_o(xfer_tx_o),
    .xfer_done_i(xfer_done_i), .xfer_rx_i(xfer_rx_i),
    .fifo_free_i(fifo_free_i), .rx_bytes_o(rx_bytes), .axis_i(axis),
    .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o), .rec_done_o(rec_done_o)
  );
endmodule

// File: rtl/accel_burst_reader_chk.sv
module accel_burst_reader_chk (
  input logic clk,
  input logic rst,
  input logic bus_req_o,
  input logic cs_n_o,
  input logic xfer_start_o,
  input logic fifo_wr_o,
  input logic rec_done_o
);
  // R5
  cs_needs_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o |-> bus_req_o);
  // R4
  start_in_select_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start_o |-> !cs_n_o);
  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start_o |=> !xfer_start_o);
  // R8
  write_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_o |-> cs_n_o && !bus_req_o);
  // R8
  done_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
    rec_done_o |-> $past(fifo_wr_o) && !fifo_wr_o);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    rec_done_o |=> !rec_done_o);
endmodule

bind accel_burst_reader accel_burst_reader_chk u_chk (
  .clk(clk), .rst(rst), .bus_req_o(bus_req_o), .cs_n_o(cs_n_o),
  .xfer_start_o(xfer_start_o), .fifo_wr_o(fifo_wr_o), .rec_done_o(rec_done_o)
);

// File: tb/tb_accel_burst_reader.sv
module tb_accel_burst_reader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic drdy_i = 1'b0, bus_gnt_i = 1'b0, xfer_done_i = 1'b0;
  logic [7:0] xfer_rx_i = '0, fifo_free_i = 8'd60;
  logic bus_req_o, cs_n_o, xfer_start_o, fifo_wr_o, rec_done_o;
  logic [7:0] xfer_tx_o;
  logic [15:0] fifo_data_o;

  always #2.5 clk = ~clk;

  accel_burst_reader dut (.*);

  int errors = 0, checks = 0, cyc = 0;
  logic [7:0] rxb [7];
  logic [7:0] txlog [7];
  logic [15:0] wrlog [8];
  int wrcyc [8];
  int n_start, n_wr, n_done, done_cyc, last_xdone_cyc, cs_rise_cyc, cs_low_n, req_rises;
  logic cs_prev = 1'b1, req_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_start = 0; n_wr = 0; n_done = 0; done_cyc = -1; last_xdone_cyc = -1;
    cs_rise_cyc = -1; cs_low_n = 0; req_rises = 0;
  endtask

  // byte engine model: reply two cycles after each start
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_start_o) begin
        if (n_start < 7) txlog[n_start] = xfer_tx_o;
        repeat (2) @(negedge clk);
        xfer_rx_i   = (n_start < 7) ? rxb[n_start] : 8'h00;
        xfer_done_i = 1'b1;
        if (cs_n_o !== 1'b0) chk(0, "R5", "cs low at byte done", cs_n_o, 0);
        last_xdone_cyc = cyc;
        n_start++;
        @(negedge clk);
        xfer_done_i = 1'b0;
      end
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (fifo_wr_o) begin
        if (n_wr < 8) begin wrlog[n_wr] = fifo_data_o; wrcyc[n_wr] = cyc; end
        n_wr++;
      end
      if (rec_done_o) begin n_done++; done_cyc = cyc; end
      if (!cs_n_o) cs_low_n++;
      if (cs_n_o && !cs_prev) cs_rise_cyc = cyc;
      if (bus_req_o && !req_prev) req_rises++;
      cs_prev  = cs_n_o;
      req_prev = bus_req_o;
    end
  end

  function automatic logic [15:0] exp_axis(input int k);
    int v;
    v = int'($signed({rxb[2*k+2], rxb[2*k+1]}));
    return 16'(v / 4);
  endfunction

  // raise data-ready at a falling edge, check request timing (R2 / R3)
  task automatic fire(input bit gnt);
    int d;
    @(negedge clk);
    bus_gnt_i = gnt;
    drdy_i = 1'b1;
    d = cyc;
    @(negedge clk); @(negedge clk);
    chk(bus_req_o == 1'b0 && cyc == d + 2, "R2", "request not before third edge", bus_req_o, 0);
    @(negedge clk);
    chk(bus_req_o == 1'b1, "R2", "request after third edge", bus_req_o, 1);
    @(negedge clk);
    if (!gnt) chk(bus_req_o == 1'b0, "R3", "request dropped without grant", bus_req_o, 0);
  endtask

  task automatic test_reset();
    chk(cs_n_o == 1 && bus_req_o == 0 && xfer_start_o == 0 && fifo_wr_o == 0 && rec_done_o == 0,
        "R1", "outputs idle after reset",
        {cs_n_o, bus_req_o, xfer_start_o, fifo_wr_o, rec_done_o}, 5'b10000);
  endtask

  task automatic test_read(input string name, input logic [7:0] free, input bit keep);
    clear_logs();
    fifo_free_i = free;
    fire(1'b1);
    repeat (100) @(negedge clk);
    chk(req_rises == 1, "R2", {name, ": one request while line held high"}, req_rises, 1);
    chk(n_start == 7, "R4", {name, ": transfer count"}, n_start, 7);
    chk(txlog[0] == 8'h82, "R4", {name, ": address byte"}, txlog[0], 8'h82);
    for (int i = 1; i < 7; i++)
      chk(txlog[i] == 8'h00, "R4", {name, ": dummy byte"}, txlog[i], 0);
    chk(cs_rise_cyc == last_xdone_cyc + 2, "R5", {name, ": select release cycle"},
        cs_rise_cyc, last_xdone_cyc + 2);
    if (keep) begin
      chk(n_wr == 3, "R8", {name, ": word count"}, n_wr, 3);
      for (int k = 0; k < 3; k++)
        chk(wrlog[k] == exp_axis(k), "R6", {name, ": axis word (R7 scaling)"}, wrlog[k], exp_axis(k));
      chk(wrcyc[0] == cs_rise_cyc + 1 && wrcyc[1] == wrcyc[0] + 1 && wrcyc[2] == wrcyc[1] + 1,
          "R8", {name, ": writes back to back after release"}, wrcyc[0], cs_rise_cyc + 1);
      chk(n_done == 1 && done_cyc == wrcyc[2] + 1, "R8", {name, ": completion pulse"},
          done_cyc, wrcyc[2] + 1);
    end else begin
      chk(n_wr == 0, "R9", {name, ": no word when FIFO short"}, n_wr, 0);
      chk(n_done == 0, "R9", {name, ": no completion when FIFO short"}, n_done, 0);
    end
    drdy_i = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic test_drop();
    clear_logs();
    fire(1'b0);
    repeat (40) @(negedge clk);
    chk(n_start == 0, "R3", "no transfer without grant", n_start, 0);
    chk(cs_low_n == 0, "R3", "select stays high", cs_low_n, 0);
    chk(n_wr == 0 && n_done == 0, "R3", "no FIFO activity", n_wr + n_done, 0);
    drdy_i = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    test_reset();
    rst = 1'b0;
    repeat (3) @(negedge clk);
    test_reset();
    // R6 byte 0 garbage ignored; positive, max and min values
    rxb = '{8'hA5, 8'h34, 8'h12, 8'hFF, 8'h7F, 8'h00, 8'h80};
    test_read("R6 basic", 8'd60, 1'b1);
    // R7 negatives: -5 -> -1, -4 -> -1, -1 -> 0
    rxb = '{8'h5A, 8'hFB, 8'hFF, 8'hFC, 8'hFF, 8'hFF, 8'hFF};
    test_read("R7 negative", 8'd60, 1'b1);
    // R7 -3 -> 0, small positive 7 -> 1, -8 -> -2
    rxb = '{8'h00, 8'hFD, 8'hFF, 8'h07, 8'h00, 8'hF8, 8'hFF};
    test_read("R7 rounding", 8'd60, 1'b1);
    test_drop();
    // R9 boundary: 5 bytes free discards, 6 keeps
    rxb = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
    test_read("R9 free5", 8'd5, 1'b0);
    test_read("R9 free6", 8'd6, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule